// File: doc/BRIEF.md
# Tagged VLIW Instruction Assembler

This block turns a stream of compact tagged instruction words into the full very long instruction word that drives a bank of functional units. The bank has `2^TAG_W` units, and each unit takes a `SLOT_W`-bit slot of the wide word. An input word carries four things: a 2-bit class, two unit tags, and the two unit fields that those tags address. A decoder and crossbar stage places field A in the slot named by tag A and field B in the slot named by tag B. Every other slot gets the no-op value, which is all zeros.

Each slot also has a holding register, so one wide instruction can be gathered over several input words. The class of each word decides what happens:

- A single word issues only its own two fields.
- A multiple word stores its fields and issues nothing.
- An insert word stores its fields and also issues the merged result, so that the next instruction can build on it.
- An end word issues the merged result and then empties every holding register.

A small controller tracks whether a gather is in progress. It has two states. IDLE means no partial instruction is held. GATHER means one is. A multiple word, an insert word or a restore write moves the controller to GATHER. An end word with no restore write moves it back to IDLE. A single word, or a cycle with no word, leaves the state unchanged. A side port reads and writes any holding register, so an interrupt handler can save and restore a partially assembled instruction.

Top module: `tvliw_assembler`

## Requirements
- R1: `vliw_valid` is high in the same cycle as a valid word of class single (00), insert (10) or end (11). It is low for class multiple (01) and when no word is valid.
- R2: A single word outputs field A at slot `iw_tag_a` and field B at slot `iw_tag_b`, with zero in all other slots. It leaves every holding register unchanged.
- R3: A multiple word drives an all-zero output. It loads field A into the register of slot `iw_tag_a` and field B into the register of slot `iw_tag_b`.
- R4: An insert word outputs its new field in each tagged slot and the held value in every other slot. It also loads its fields the same way a multiple word does.
- R5: An end word outputs the same merged word as an insert word. After the clock edge, every holding register reads zero.
- R6: `tag_clash` is high exactly when a valid word carries two equal tags. In that case, field A is the one used for the shared slot.
- R7: `ctx_rdata` shows, in the same cycle, the holding register of slot `ctx_sel`.
- R8: A write with `ctx_we` high loads `ctx_wdata` into slot `ctx_sel` at the clock edge. It wins over any load or clear from the current word for that slot.
- R9: After reset, every holding register reads zero, `asm_pending` is low and the output is all zero.
- R10: `asm_pending` (high in GATHER) rises after a multiple word, an insert word or a restore write. It falls after an end word that has no restore write. Single words and empty cycles leave it unchanged.
- R11: When `iw_valid` is low, the output is all zero, `tag_clash` is low and no holding register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iw_valid | input | 1 | A compact word is present this cycle |
| iw_class | input | 2 | Word class: 00 single, 01 multiple, 10 insert, 11 end |
| iw_tag_a | input | TAG_W | Unit addressed by field A |
| iw_tag_b | input | TAG_W | Unit addressed by field B |
| iw_field_a | input | SLOT_W | Unit instruction field A |
| iw_field_b | input | SLOT_W | Unit instruction field B |
| ctx_sel | input | TAG_W | Holding register selected for save or restore |
| ctx_we | input | 1 | Restore write strobe |
| ctx_wdata | input | SLOT_W | Restore write data |
| ctx_rdata | output | SLOT_W | Contents of the selected holding register |
| vliw_out | output | 2^TAG_W*SLOT_W | Assembled wide word; slot k is bits [k*SLOT_W +: SLOT_W] |
| vliw_valid | output | 1 | The wide word is issued this cycle |
| tag_clash | output | 1 | Both tags of the valid word name the same unit |
| asm_pending | output | 1 | A partial instruction is held (controller in GATHER) |

## Verification
The bench builds the block with TAG_W=2 and SLOT_W=4, which gives four slots and a 16-bit wide word. At that size it can sweep every class against every ordered pair of tags, including the four pairs with equal tags. The expected wide word is recomputed slot by slot from a bench-side copy of the holding registers. The small slot count also lets the bench save and restore the whole context through the side port, and it checks that a restore write takes priority over a clear in the same cycle.

// File: rtl/tvliw_pkg.sv
package tvliw_pkg;

    typedef enum logic [1:0] {
        CLS_SINGLE = 2'b00,
        CLS_MULTI  = 2'b01,
        CLS_INSERT = 2'b10,
        CLS_END    = 2'b11
    } iw_class_e;

    typedef enum logic [1:0] {
        OUT_NOP   = 2'd0,
        OUT_MID   = 2'd1,
        OUT_MERGE = 2'd2
    } out_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_GATHER = 1'b1
    } asm_state_e;

endpackage

// File: rtl/tvliw_tag_decode.sv
module tvliw_tag_decode #(
    parameter int TAG_W = 5,
    localparam int NUM_SLOTS = 1 << TAG_W
) (
    input  logic                 en,
    input  logic [TAG_W-1:0]     tag,
    output logic [NUM_SLOTS-1:0] onehot
);

    // One comparator per slot; the slot is selected when the tag matches its index.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
        assign onehot[s] = en && (tag == TAG_W'(s));
    end

endmodule

// File: rtl/tvliw_crossbar.sv
module tvliw_crossbar #(
    parameter int TAG_W  = 5,
    parameter int SLOT_W = 8,
    localparam int NUM_SLOTS = 1 << TAG_W
) (
    input  logic [NUM_SLOTS-1:0]             hit_a,
    input  logic [NUM_SLOTS-1:0]             hit_b,
    input  logic [SLOT_W-1:0]                field_a,
    input  logic [SLOT_W-1:0]                field_b,
    output logic [NUM_SLOTS-1:0][SLOT_W-1:0] mid,
    output logic [NUM_SLOTS-1:0]             hit
);

    // Field A outranks field B on a shared slot; untouched slots carry the zero no-op.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_xbar
        always_comb begin
            if (hit_a[s]) begin
                mid[s] = field_a;
            end else if (hit_b[s]) begin
                mid[s] = field_b;
            end else begin
                mid[s] = '0;
            end
        end
        assign hit[s] = hit_a[s] | hit_b[s];
    end

endmodule

// File: rtl/tvliw_seq_ctrl.sv
module tvliw_seq_ctrl
    import tvliw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      iw_valid,
    input  logic [1:0] iw_class,
    input  logic      ctx_we,
    output out_mode_e mode,
    output logic      load_en,
    output logic      clear_en,
    output logic      vliw_valid,
    output logic      asm_pending
);

    iw_class_e  cls;
    asm_state_e state_q, state_d;

    assign cls = iw_class_e'(iw_class);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a restore write always leaves a partial instruction behind.
    always_comb begin
        state_d = state_q;
        if (ctx_we) begin
            state_d = ST_GATHER;
        end else if (iw_valid) begin
            unique case (cls)
                CLS_SINGLE: state_d = state_q;
                CLS_MULTI:  state_d = ST_GATHER;
                CLS_INSERT: state_d = ST_GATHER;
                CLS_END:    state_d = ST_IDLE;
                default:    state_d = state_q;
            endcase
        end
    end

    // Output decode: per-class mux mode, store strobes and issue flag.
    always_comb begin
        mode       = OUT_NOP;
        load_en    = 1'b0;
        clear_en   = 1'b0;
        vliw_valid = 1'b0;
        if (iw_valid) begin
            unique case (cls)
                CLS_SINGLE: begin
                    mode       = OUT_MID;
                    vliw_valid = 1'b1;
                end
                CLS_MULTI: begin
                    mode    = OUT_NOP;
                    load_en = 1'b1;
                end
                CLS_INSERT: begin
                    mode       = OUT_MERGE;
                    load_en    = 1'b1;
                    vliw_valid = 1'b1;
                end
                CLS_END: begin
                    mode       = OUT_MERGE;
                    clear_en   = 1'b1;
                    vliw_valid = 1'b1;
                end
                default: mode = OUT_NOP;
            endcase
        end
    end

    assign asm_pending = (state_q == ST_GATHER);

endmodule

// File: rtl/tvliw_slot_store.sv
module tvliw_slot_store
    import tvliw_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int SLOT_W = 8,
    localparam int NUM_SLOTS = 1 << TAG_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SLOTS-1:0][SLOT_W-1:0] mid,
    input  logic [NUM_SLOTS-1:0]             hit,
    input  out_mode_e                        mode,
    input  logic                             load_en,
    input  logic                             clear_en,
    input  logic                             ctx_we,
    input  logic [TAG_W-1:0]                 ctx_sel,
    input  logic [SLOT_W-1:0]                ctx_wdata,
    output logic [NUM_SLOTS-1:0][SLOT_W-1:0] held,
    output logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_out
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic restore_here;
        assign restore_here = ctx_we && (ctx_sel == TAG_W'(s));

        // Holding register: restore write, then class load, then class clear.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[s] <= '0;
            end else if (restore_here) begin
                held[s] <= ctx_wdata;
            end else if (load_en && hit[s]) begin
                held[s] <= mid[s];
            end else if (clear_en) begin
                held[s] <= '0;
            end
        end

        // Three-way output select per slot.
        always_comb begin
            unique case (mode)
                OUT_NOP:   slot_out[s] = '0;
                OUT_MID:   slot_out[s] = mid[s];
                OUT_MERGE: slot_out[s] = hit[s] ? mid[s] : held[s];
                default:   slot_out[s] = '0;
            endcase
        end
    end

endmodule

// File: rtl/tvliw_assembler.sv
module tvliw_assembler
    import tvliw_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int SLOT_W = 8,
    localparam int NUM_SLOTS = 1 << TAG_W,
    localparam int VLIW_W    = NUM_SLOTS * SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iw_valid,
    input  logic [1:0]        iw_class,
    input  logic [TAG_W-1:0]  iw_tag_a,
    input  logic [TAG_W-1:0]  iw_tag_b,
    input  logic [SLOT_W-1:0] iw_field_a,
    input  logic [SLOT_W-1:0] iw_field_b,
    input  logic [TAG_W-1:0]  ctx_sel,
    input  logic              ctx_we,
    input  logic [SLOT_W-1:0] ctx_wdata,
    output logic [SLOT_W-1:0] ctx_rdata,
    output logic [VLIW_W-1:0] vliw_out,
    output logic              vliw_valid,
    output logic              tag_clash,
    output logic              asm_pending
);

    logic [NUM_SLOTS-1:0]             hit_a, hit_b, hit;
    logic [NUM_SLOTS-1:0][SLOT_W-1:0] mid, held, slot_out;
    out_mode_e                        mode;
    logic                             load_en, clear_en;

    tvliw_tag_decode #(.TAG_W(TAG_W)) u_dec_a (
        .en(iw_valid), .tag(iw_tag_a), .onehot(hit_a)
    );

    tvliw_tag_decode #(.TAG_W(TAG_W)) u_dec_b (
        .en(iw_valid), .tag(iw_tag_b), .onehot(hit_b)
    );

    tvliw_crossbar #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_xbar (
        .hit_a(hit_a), .hit_b(hit_b),
        .field_a(iw_field_a), .field_b(iw_field_b),
        .mid(mid), .hit(hit)
    );

    tvliw_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .iw_valid(iw_valid), .iw_class(iw_class), .ctx_we(ctx_we),
        .mode(mode), .load_en(load_en), .clear_en(clear_en),
        .vliw_valid(vliw_valid), .asm_pending(asm_pending)
    );

    tvliw_slot_store #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .mid(mid), .hit(hit), .mode(mode),
        .load_en(load_en), .clear_en(clear_en),
        .ctx_we(ctx_we), .ctx_sel(ctx_sel), .ctx_wdata(ctx_wdata),
        .held(held), .slot_out(slot_out)
    );

    // The two one-hot decodes overlap only when both tags point at one unit.
    assign tag_clash = |(hit_a & hit_b);
    assign ctx_rdata = held[ctx_sel];
    assign vliw_out  = slot_out;

endmodule

// File: rtl/tvliw_assembler_chk.sv
module tvliw_assembler_chk #(
    parameter int TAG_W  = 5,
    parameter int SLOT_W = 8,
    localparam int VLIW_W = (1 << TAG_W) * SLOT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iw_valid,
    input logic [1:0]        iw_class,
    input logic [TAG_W-1:0]  iw_tag_a,
    input logic [TAG_W-1:0]  iw_tag_b,
    input logic [TAG_W-1:0]  ctx_sel,
    input logic              ctx_we,
    input logic [SLOT_W-1:0] ctx_wdata,
    input logic [SLOT_W-1:0] ctx_rdata,
    input logic [VLIW_W-1:0] vliw_out,
    input logic              vliw_valid,
    input logic              tag_clash,
    input logic              asm_pending
);

    assert_multi_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_valid && iw_class == 2'b01) |-> (vliw_out == '0 && !vliw_valid));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !iw_valid |-> (vliw_out == '0 && !vliw_valid && !tag_clash));

    assert_clash_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_valid && iw_tag_a == iw_tag_b) |-> tag_clash);

    assert_end_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_valid && iw_class == 2'b11 && !ctx_we) |=> (ctx_rdata == '0));

    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_valid && iw_class == 2'b11 && !ctx_we) |=> !asm_pending);

    assert_restore_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_we |=> asm_pending);

    assert_restore_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_we |=> (!$stable(ctx_sel) || ctx_rdata == $past(ctx_wdata)));

    assert_single_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_valid && iw_class == 2'b00 && !ctx_we) |=> (!$stable(ctx_sel) || $stable(ctx_rdata)));

endmodule

bind tvliw_assembler tvliw_assembler_chk #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .iw_valid(iw_valid), .iw_class(iw_class),
    .iw_tag_a(iw_tag_a), .iw_tag_b(iw_tag_b), .ctx_sel(ctx_sel),
    .ctx_we(ctx_we), .ctx_wdata(ctx_wdata), .ctx_rdata(ctx_rdata),
    .vliw_out(vliw_out), .vliw_valid(vliw_valid), .tag_clash(tag_clash),
    .asm_pending(asm_pending)
);

// File: tb/sim_tvliw_assembler.sv
`timescale 1ns/1ps
module sim_tvliw_assembler;

    localparam int TW = 2;
    localparam int SW = 4;
    localparam int NS = 1 << TW;
    localparam int VW = NS * SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iw_valid = 1'b0;
    logic [1:0]    iw_class = '0;
    logic [TW-1:0] iw_tag_a = '0, iw_tag_b = '0;
    logic [SW-1:0] iw_field_a = '0, iw_field_b = '0;
    logic [TW-1:0] ctx_sel = '0;
    logic          ctx_we = 1'b0;
    logic [SW-1:0] ctx_wdata = '0;
    logic [SW-1:0] ctx_rdata;
    logic [VW-1:0] vliw_out;
    logic          vliw_valid, tag_clash, asm_pending;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [SW-1:0] m_held [NS];
    bit            m_pend;

    always #2.5 clk = ~clk;

    tvliw_assembler #(.TAG_W(TW), .SLOT_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .iw_valid(iw_valid), .iw_class(iw_class),
        .iw_tag_a(iw_tag_a), .iw_tag_b(iw_tag_b),
        .iw_field_a(iw_field_a), .iw_field_b(iw_field_b),
        .ctx_sel(ctx_sel), .ctx_we(ctx_we), .ctx_wdata(ctx_wdata),
        .ctx_rdata(ctx_rdata), .vliw_out(vliw_out), .vliw_valid(vliw_valid),
        .tag_clash(tag_clash), .asm_pending(asm_pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at falling edge, compare mid-cycle, update bench model at rising edge.
    task automatic step(input bit v, input int c, input int ta, input int tb,
                        input int fa, input int fb, input bit we, input int sel, input int wd);
        logic [VW-1:0] exp_out;
        logic [SW-1:0] midv [NS];
        bit            hitv [NS];
        string         tag;
        @(negedge clk);
        iw_valid = v; iw_class = 2'(c);
        iw_tag_a = TW'(ta); iw_tag_b = TW'(tb);
        iw_field_a = SW'(fa); iw_field_b = SW'(fb);
        ctx_we = we; ctx_sel = TW'(sel); ctx_wdata = SW'(wd);
        #1;
        exp_out = '0;
        for (int s = 0; s < NS; s++) begin
            hitv[s] = v && (ta == s || tb == s);
            midv[s] = !v ? SW'(0) : (ta == s) ? SW'(fa) : (tb == s) ? SW'(fb) : SW'(0);
            if (v && c == 0)      exp_out[s*SW +: SW] = midv[s];
            else if (v && c >= 2) exp_out[s*SW +: SW] = hitv[s] ? midv[s] : m_held[s];
        end
        tag = !v ? "R11" : (c == 0) ? "R2" : (c == 1) ? "R3" : (c == 2) ? "R4" : "R5";
        chk(tag, 32'(vliw_out), 32'(exp_out));
        if (v && ta == tb) chk("R6 field A wins", 32'(vliw_out), 32'(exp_out));
        chk("R1 valid", 32'(vliw_valid), 32'(v && c != 1));
        chk("R6 clash", 32'(tag_clash), 32'(v && ta == tb));
        chk("R7 readback", 32'(ctx_rdata), 32'(m_held[sel]));
        chk("R10 pending", 32'(asm_pending), 32'(m_pend));
        @(posedge clk);
        for (int s = 0; s < NS; s++) begin
            if (we && sel == s)                   m_held[s] = SW'(wd);
            else if (v && (c == 1 || c == 2) && hitv[s]) m_held[s] = midv[s];
            else if (v && c == 3)                 m_held[s] = '0;
        end
        if (we)                          m_pend = 1'b1;
        else if (v && (c == 1 || c == 2)) m_pend = 1'b1;
        else if (v && c == 3)            m_pend = 1'b0;
    endtask

    initial begin
        for (int s = 0; s < NS; s++) m_held[s] = '0;
        m_pend = 1'b0;
        #1;
        // R9: reset state visible while reset is held.
        chk("R9 out", 32'(vliw_out), 32'h0);
        chk("R9 pending", 32'(asm_pending), 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int s = 0; s < NS; s++) step(0, 0, 0, 0, 0, 0, 0, s, 0); // R9 readback of every slot

        // Sweep every class against every ordered tag pair.
        for (int c = 0; c < 4; c++)
            for (int ta = 0; ta < NS; ta++)
                for (int tb = 0; tb < NS; tb++)
                    step(1, c, ta, tb, (ta*5 + tb*3 + c*7 + 1) % 16,
                         (ta*5 + tb*3 + c*7 + 10) % 16, 0, (ta + tb + c) % NS, 0);

        // R11: idle cycles with noisy fields change nothing.
        step(1, 1, 0, 3, 9, 6, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(0, i % 4, i % NS, (i + 1) % NS, i + 3, i + 7, 0, i % NS, 0);

        // Gather: multiple, insert reusing, end issuing merged word.
        step(1, 1, 1, 2, 4'hA, 4'hB, 0, 1, 0);
        step(1, 2, 0, 0, 4'hC, 4'hD, 0, 2, 0);
        step(1, 0, 3, 1, 4'h5, 4'h6, 0, 0, 0);   // single leaves store intact (R2)
        step(1, 3, 3, 3, 4'hE, 4'h1, 0, 3, 0);

        // Interrupt: build partial, save all slots, clear, restore, finish.
        step(1, 1, 0, 1, 4'h3, 4'h7, 0, 0, 0);
        step(1, 2, 2, 3, 4'h9, 4'h2, 0, 1, 0);
        for (int s = 0; s < NS; s++) step(0, 0, 0, 0, 0, 0, 0, s, 0);
        step(1, 3, 0, 1, 4'h0, 4'h0, 0, 0, 0);
        for (int s = 0; s < NS; s++) step(0, 0, 0, 0, 0, 0, 1, s, (s * 3 + 4) % 16); // R8
        for (int s = 0; s < NS; s++) step(0, 0, 0, 0, 0, 0, 0, s, 0);
        step(1, 3, 1, 2, 4'hF, 4'h8, 1, 0, 4'h6);  // R8 restore beats end clear
        for (int s = 0; s < NS; s++) step(0, 0, 0, 0, 0, 0, 0, s, 0);
        step(1, 1, 0, 0, 4'h5, 4'h9, 1, 0, 4'hB);  // R8 restore beats load
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 3, 2, 2, 4'h1, 4'h2, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule